// File: doc/BRIEF.md
# Calibration Fuse Chain Controller

This block holds factory calibration in a chain of one-bit slices. Each slice pairs a shift-register flip-flop with a model of a non-volatile cell. The cell model is a register that is cleared only by a power-on reset. A small command port drives the chain. A host enters calibration mode, clocks the chain one bit per command, and can preview the result on the configuration outputs. It then burns the chain into the cells and leaves the mode.

Programming can only set cells, never clear them. The last bit of the chain is a seal, and once its cell is set, calibration mode can never be entered again. A factory-defaults cell, once set, forces the stored values into use. While that cell is clear, the host chooses whether the stored values apply by sending a set-defaults command with an enable argument.

Top module: `otp_cal_ctrl`

## Requirements
- R1: When `rst_n` is released, calibration mode and the host defaults enable are clear. At the first clock edge after release, the shift register is loaded from the cells, and any command in that cycle is ignored.
- R2: Command code 1 enters calibration mode unless the seal cell is set. Command code 2 leaves calibration mode, and `cal_active` shows the mode from the next cycle.
- R3: In calibration mode, code 3 shifts a 0 and code 4 shifts a 1 into chain bit 0, and every other bit moves up one place. A full load takes VPR_W+BIAS_W+2 shifts in this order: the voltage field MSB first, then the bias field MSB first, then the factory-defaults bit, then the seal bit last.
- R4: Shift commands received outside calibration mode leave the shift register, and so `cfg_vpr` and `cfg_bias`, unchanged.
- R5: `cfg_vpr` and `cfg_bias` always show the voltage and bias fields of the shift register, so shifted data is visible while calibration mode is still active.
- R6: Code 5 in calibration mode sets every cell whose shift-register bit is 1 and leaves all other cells unchanged. A cell never returns from 1 to 0 except through `por_n`. Code 5 outside calibration mode has no effect.
- R7: Code 6 latches `cmd_arg` as the host defaults enable. `cfg_use_otp` is 1 when the factory-defaults cell is set, or the host enable is set, or calibration mode is active with the chain's factory-defaults bit at 1.
- R8: Once the factory-defaults cell is set, `cfg_use_otp` stays 1 and a code 6 with argument 0 cannot clear it.
- R9: Once the seal cell is set, code 1 is ignored across any number of `rst_n` pulses, and shifts stay ignored.
- R10: `por_n` low clears all cells. This models a fresh, unprogrammed part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears the cell model |
| rst_n | input | 1 | Functional reset, asynchronous, active low; reload from cells follows |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_code | input | 3 | Command code (0 no-op, 1 enter, 2 exit, 3 shift 0, 4 shift 1, 5 program, 6 set defaults) |
| cmd_arg | input | 1 | Enable argument of the set-defaults command |
| cfg_vpr | output | VPR_W | Voltage setting field of the chain |
| cfg_bias | output | BIAS_W | Bias field of the chain |
| cfg_use_otp | output | 1 | Stored configuration is in force |
| cal_active | output | 1 | Calibration mode is active |

## Verification
The bench builds the block with its defaults: an 8-bit voltage field and a 3-bit bias field, so the chain is 13 bits long. With this length, a complete load, preview, program, reset and reload cycle runs many times within a short test. The 8-bit field is wide enough to show that programming ORs in new bits over an earlier pattern instead of replacing it. Both lock cells sit at fixed low chain positions, so the sealing and factory-defaults paths can be reached directly after a few loads.

// File: rtl/otp_cal_pkg.sv
package otp_cal_pkg;
  typedef enum logic [2:0] {
    CMD_NOP       = 3'd0,
    CMD_CAL_ENTER = 3'd1,
    CMD_CAL_EXIT  = 3'd2,
    CMD_SHIFT0    = 3'd3,
    CMD_SHIFT1    = 3'd4,
    CMD_PROGRAM   = 3'd5,
    CMD_SET_DFLT  = 3'd6
  } otp_cmd_e;

  localparam int SEAL_POS = 0;
  localparam int FDEF_POS = 1;
endpackage

// File: rtl/otp_slice.sv
module otp_slice (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic load_i,
  input  logic shift_i,
  input  logic shin_i,
  input  logic prog_i,
  output logic sr_o,
  output logic cell_o
);
  logic sr_q, sr_d;
  logic cell_q, cell_d;

  always_comb begin
    sr_d = sr_q;
    if (load_i)       sr_d = cell_q;
    else if (shift_i) sr_d = shin_i;
  end

  always_comb begin
    cell_d = cell_q;
    if (prog_i && sr_q) cell_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 1'b0;
    else if (load_i || shift_i) sr_q <= sr_d;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cell_q <= 1'b0;
    else if (prog_i) cell_q <= cell_d;
  end

  assign sr_o   = sr_q;
  assign cell_o = cell_q;
endmodule

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl
  import otp_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       cmd_arg,
  input  logic       seal_cell,
  input  logic       fdef_cell,
  output logic       load_o,
  output logic       shift_o,
  output logic       shin_o,
  output logic       prog_o,
  output logic       cal_o,
  output logic       dflt_o
);
  logic     load_q;
  logic     cal_q, cal_d;
  logic     dflt_q, dflt_d;
  logic     take;
  otp_cmd_e cmd;

  assign cmd  = otp_cmd_e'(cmd_code);
  assign take = cmd_valid && !load_q;

  always_comb begin
    cal_d   = cal_q;
    dflt_d  = dflt_q;
    shift_o = 1'b0;
    shin_o  = 1'b0;
    prog_o  = 1'b0;
    if (take) begin
      unique case (cmd)
        CMD_CAL_ENTER: if (!seal_cell) cal_d = 1'b1;
        CMD_CAL_EXIT:  cal_d = 1'b0;
        CMD_SHIFT0:    shift_o = cal_q;
        CMD_SHIFT1: begin
          shift_o = cal_q;
          shin_o  = 1'b1;
        end
        CMD_PROGRAM:   prog_o = cal_q;
        CMD_SET_DFLT:  if (!fdef_cell) dflt_d = cmd_arg;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b1;
      cal_q  <= 1'b0;
      dflt_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (take) begin
        cal_q  <= cal_d;
        dflt_q <= dflt_d;
      end
    end
  end

  assign load_o = load_q;
  assign cal_o  = cal_q;
  assign dflt_o = dflt_q;
endmodule

// File: rtl/otp_cfg_map.sv
module otp_cfg_map
  import otp_cal_pkg::*;
#(
  parameter int VPR_W  = 8,
  parameter int BIAS_W = 3,
  localparam int CHAIN_W  = VPR_W + BIAS_W + 2,
  localparam int BIAS_LSB = FDEF_POS + 1,
  localparam int VPR_LSB  = BIAS_LSB + BIAS_W
) (
  input  logic [CHAIN_W-1:0] sr_i,
  input  logic               fdef_cell,
  input  logic               dflt_en,
  input  logic               cal_en,
  output logic [VPR_W-1:0]   vpr_o,
  output logic [BIAS_W-1:0]  bias_o,
  output logic               use_o
);
  assign vpr_o  = sr_i[VPR_LSB +: VPR_W];
  assign bias_o = sr_i[BIAS_LSB +: BIAS_W];
  assign use_o  = fdef_cell | dflt_en | (cal_en & sr_i[FDEF_POS]);
endmodule

// File: rtl/otp_cal_ctrl.sv
module otp_cal_ctrl
  import otp_cal_pkg::*;
#(
  parameter int VPR_W  = 8,
  parameter int BIAS_W = 3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_code,
  input  logic              cmd_arg,
  output logic [VPR_W-1:0]  cfg_vpr,
  output logic [BIAS_W-1:0] cfg_bias,
  output logic              cfg_use_otp,
  output logic              cal_active
);
  localparam int CHAIN_W = VPR_W + BIAS_W + 2;

  logic [CHAIN_W-1:0] sr_vec;
  logic [CHAIN_W-1:0] cell_vec;
  logic [CHAIN_W-1:0] shin_vec;
  logic load_pend, shift_en, shift_bit, prog_en, dflt_en;

  otp_mode_ctrl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_arg   (cmd_arg),
    .seal_cell (cell_vec[SEAL_POS]),
    .fdef_cell (cell_vec[FDEF_POS]),
    .load_o    (load_pend),
    .shift_o   (shift_en),
    .shin_o    (shift_bit),
    .prog_o    (prog_en),
    .cal_o     (cal_active),
    .dflt_o    (dflt_en)
  );

  assign shin_vec = {sr_vec[CHAIN_W-2:0], shift_bit};

  for (genvar g = 0; g < CHAIN_W; g++) begin : g_slice
    otp_slice u_slice (
      .clk     (clk),
      .por_n   (por_n),
      .rst_n   (rst_n),
      .load_i  (load_pend),
      .shift_i (shift_en),
      .shin_i  (shin_vec[g]),
      .prog_i  (prog_en),
      .sr_o    (sr_vec[g]),
      .cell_o  (cell_vec[g])
    );
  end

  otp_cfg_map #(.VPR_W(VPR_W), .BIAS_W(BIAS_W)) u_map (
    .sr_i      (sr_vec),
    .fdef_cell (cell_vec[FDEF_POS]),
    .dflt_en   (dflt_en),
    .cal_en    (cal_active),
    .vpr_o     (cfg_vpr),
    .bias_o    (cfg_bias),
    .use_o     (cfg_use_otp)
  );
endmodule

// File: rtl/otp_cal_ctrl_chk.sv
module otp_cal_ctrl_chk #(
  parameter int CHAIN_W = 13
) (
  input logic               clk,
  input logic               por_n,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [2:0]         cmd_code,
  input logic               cal_active,
  input logic               cfg_use_otp,
  input logic               load_pend,
  input logic [CHAIN_W-1:0] sr_q,
  input logic [CHAIN_W-1:0] cell_q
);
  // R6: cells only move from 0 to 1
  assert_cell_no_clear_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (($past(cell_q) & ~cell_q) == '0));

  // R9: entry never happens with the seal cell set
  assert_seal_blocks_R9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(cal_active) |-> !$past(cell_q[0]));

  // R4: shifts outside calibration mode leave the chain alone
  assert_shift_ignored_R4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (cmd_valid && (cmd_code == 3'd3 || cmd_code == 3'd4) && !cal_active && !load_pend)
      |=> $stable(sr_q));

  // R2: exit command clears the mode on the next cycle
  assert_exit_clears_R2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (cmd_valid && cmd_code == 3'd2 && !load_pend) |=> !cal_active);

  // R8: programmed factory-defaults cell forces use of stored values
  assert_fdef_forces_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    cell_q[1] |-> cfg_use_otp);
endmodule

bind otp_cal_ctrl otp_cal_ctrl_chk #(.CHAIN_W(CHAIN_W)) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_code    (cmd_code),
  .cal_active  (cal_active),
  .cfg_use_otp (cfg_use_otp),
  .load_pend   (load_pend),
  .sr_q        (sr_vec),
  .cell_q      (cell_vec)
);

// File: tb/otp_cal_ctrl_bench.sv
module otp_cal_ctrl_bench;
  localparam int VPR_W  = 8;
  localparam int BIAS_W = 3;

  logic clk = 1'b0;
  logic por_n, rst_n, cmd_valid, cmd_arg;
  logic [2:0] cmd_code;
  logic [VPR_W-1:0]  cfg_vpr;
  logic [BIAS_W-1:0] cfg_bias;
  logic cfg_use_otp, cal_active;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  otp_cal_ctrl #(.VPR_W(VPR_W), .BIAS_W(BIAS_W)) u_otp_cal_ctrl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_arg(cmd_arg), .cfg_vpr(cfg_vpr),
    .cfg_bias(cfg_bias), .cfg_use_otp(cfg_use_otp), .cal_active(cal_active)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [2:0] code, input logic arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 3'd0; cmd_arg = 1'b0;
  endtask

  task automatic func_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_chain(input logic [VPR_W-1:0] v, input logic [BIAS_W-1:0] b,
                            input logic fd, input logic seal);
    for (int i = VPR_W - 1; i >= 0; i--) send(v[i] ? 3'd4 : 3'd3, 1'b0);
    for (int i = BIAS_W - 1; i >= 0; i--) send(b[i] ? 3'd4 : 3'd3, 1'b0);
    send(fd ? 3'd4 : 3'd3, 1'b0);
    send(seal ? 3'd4 : 3'd3, 1'b0);
  endtask

  task automatic t_reset();
    check("R10 vpr fresh", cfg_vpr, 0);
    check("R1 bias", cfg_bias, 0);
    check("R1 use", cfg_use_otp, 0);
    check("R1 cal", cal_active, 0);
  endtask

  task automatic t_shift_outside();
    send(3'd4, 1'b0); send(3'd4, 1'b0); send(3'd4, 1'b0);
    check("R4 vpr", cfg_vpr, 0);
    check("R4 bias", cfg_bias, 0);
  endtask

  task automatic t_preview();
    send(3'd1, 1'b0);
    check("R2 enter", cal_active, 1);
    load_chain(8'hD0, 3'd5, 1'b0, 1'b0);
    check("R3 R5 vpr", cfg_vpr, 8'hD0);
    check("R3 R5 bias", cfg_bias, 5);
    check("R7 use idle", cfg_use_otp, 0);
    send(3'd6, 1'b1);
    check("R7 dflt on", cfg_use_otp, 1);
    send(3'd6, 1'b0);
    check("R7 dflt off", cfg_use_otp, 0);
    send(3'd2, 1'b0);
    check("R2 exit", cal_active, 0);
    send(3'd5, 1'b0);
    func_reset();
    check("R6 no program", cfg_vpr, 0);
  endtask

  task automatic t_program();
    send(3'd1, 1'b0);
    load_chain(8'hD0, 3'd5, 1'b0, 1'b0);
    send(3'd5, 1'b0);
    send(3'd2, 1'b0);
    func_reset();
    check("R1 R6 reload vpr", cfg_vpr, 8'hD0);
    check("R1 R6 reload bias", cfg_bias, 5);
    send(3'd1, 1'b0);
    load_chain(8'h0F, 3'd0, 1'b0, 1'b0);
    check("R5 preview", cfg_vpr, 8'h0F);
    send(3'd5, 1'b0);
    send(3'd2, 1'b0);
    func_reset();
    check("R6 one way vpr", cfg_vpr, 8'hDF);
    check("R6 one way bias", cfg_bias, 5);
  endtask

  task automatic t_factory();
    send(3'd1, 1'b0);
    load_chain(8'hDF, 3'd5, 1'b1, 1'b0);
    send(3'd5, 1'b0);
    send(3'd2, 1'b0);
    check("R8 use", cfg_use_otp, 1);
    send(3'd6, 1'b0);
    check("R8 locked", cfg_use_otp, 1);
  endtask

  task automatic t_seal();
    send(3'd1, 1'b0);
    load_chain(8'hDF, 3'd5, 1'b1, 1'b1);
    send(3'd5, 1'b0);
    send(3'd2, 1'b0);
    func_reset();
    send(3'd1, 1'b0);
    check("R9 blocked", cal_active, 0);
    send(3'd3, 1'b0);
    check("R9 shift ignored", cfg_vpr, 8'hDF);
    func_reset();
    send(3'd1, 1'b0);
    check("R9 blocked again", cal_active, 0);
  endtask

  initial begin
    por_n = 1'b0; rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_code = 3'd0; cmd_arg = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_shift_outside();
    t_preview();
    t_program();
    t_factory();
    t_seal();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule